// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Routed Error Interrupts

This block receives asynchronous serial frames. It takes one serial input and an oversampling tick from an external rate generator. After a falling edge on the line, it checks the start bit at the middle of the bit time. It then collects eight data bits, least significant bit first, an optional parity bit and one stop bit. Each bit is taken at its mid-bit tick.

When the stop bit is sampled, the assembled byte is written into a receive holding register. A one-cycle interrupt pulse is raised in the same clock cycle.

Errors never cut a frame short. A parity or framing error still delivers the byte. An overrun keeps the old byte and drops the new one. For any frame that ends with an error, a routing bit selects which pulse is raised: the normal completion pulse or a separate error pulse.

Dropping the receive enable in the middle of a frame abandons the frame without any trace. The buffer and the sticky error flags keep their values, and no pulse is raised. Software reads the byte with a read strobe, which frees the buffer. It clears the error flags with a separate clear strobe.

Top module: `uart_rx_core`

## Requirements
- R1: The receiver stays idle unless both `unit_en_i` and `rx_en_i` are 1. While idle for this reason, `rx_data_o` keeps its value and neither `done_irq_o` nor `err_irq_o` is raised.
- R2: The line value that counts is the one after a two-flop synchronizer. A 1-to-0 transition of this value starts a frame. The start bit is accepted only if the line is still 0 at tick OVS/2 after the edge. If it is not, the receiver returns to idle and raises no pulse.
- R3: A frame carries 8 data bits, LSB first, each sampled OVS ticks after the previous bit. When the stop bit is sampled, the byte appears on `rx_data_o`, `buf_full_o` goes to 1, and a single-cycle pulse is raised, all in the same cycle.
- R4: With `par_en_i`=1, one parity bit follows the data. The count of ones across the data and the parity bit must be even when `par_odd_i`=0 and odd when it is 1. On a mismatch, `par_err_o` is set and the byte is still written to `rx_data_o`.
- R5: A stop bit sampled as 0 sets `frm_err_o`. The frame still completes and the byte is still written to `rx_data_o`.
- R6: If `buf_full_o` is 1 when a frame completes and `buf_rd_i` is not asserted in that cycle, `rx_data_o` keeps its old value and `ovr_err_o` is set.
- R7: A frame with no error raises `done_irq_o`. A frame with any error raises `done_irq_o` when `err_route_i`=0 and `err_irq_o` when `err_route_i`=1. The two pulses are never high together.
- R8: If `rx_en_i` falls to 0 during a frame, reception stops and the receiver returns to idle. `rx_data_o` and the three error flags are left unchanged, and no pulse is raised.
- R9: `buf_rd_i` clears `buf_full_o`. `stat_clr_i` clears `par_err_o`, `frm_err_o` and `ovr_err_o`. A flag being set in the same cycle wins over the clear.
- R10: After reset, `rx_data_o`=0, all flags are 0 and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling tick, OVS per bit |
| unit_en_i | input | 1 | Unit enable |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| err_route_i | input | 1 | 1 = errored frames use the error pulse |
| buf_rd_i | input | 1 | Buffer read strobe, clears full flag |
| stat_clr_i | input | 1 | Clears the error flags |
| rx_data_o | output | DATA_W | Receive holding register |
| buf_full_o | output | 1 | Holding register holds an unread byte |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |
| ovr_err_o | output | 1 | Sticky overrun error |
| done_irq_o | output | 1 | Frame-complete pulse |
| err_irq_o | output | 1 | Error pulse |

## Verification
The bench builds the receiver with OVS=8 and DATA_W=8, and it delivers one tick every four clocks. This makes a bit last 32 clocks and the start qualification fall at the fourth tick. Frames, glitches and mid-frame disables therefore fit easily in the cycle budget.

With these settings, every error type, both parity senses and both routing choices are covered. Overrun is exercised by leaving the buffer unread. A line glitch shorter than half a bit and a disable after three data bits are also applied. All of this is compared every clock against a behavioural model.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
// rx_line_sync: brings the asynchronous serial line into the clock domain
// and flags a high-to-low transition of the synchronized value.
// Assumes the line idles high; all stages reset to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // one synchronizer flop per stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else if (g == 0) begin
                    chain[g] <= rx_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // remember the last synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain[STAGES-1];
    end

    assign rx_o   = chain[STAGES-1];
    assign fall_o = prev_q & ~chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// rx_framer: frame sequencer. Qualifies the start bit at the mid-bit tick,
// shifts data LSB first, samples optional parity and the stop bit, and
// strobes done_o in the cycle the stop bit is sampled. Losing armed_i
// returns to idle at once without a strobe.
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              fall_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              pe_o,
    output logic              fe_o
);
    localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pbit_q;
    logic              bit_pt;

    // a full bit period has elapsed on this tick
    assign bit_pt = tick_i && (cnt_q == LAST_T);

    // frame sequencing, tick counting and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            pbit_q  <= 1'b0;
        end else if (!armed_i) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fall_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (tick_i) begin
                        if (cnt_q == MID_T) begin
                            cnt_q   <= '0;
                            bit_q   <= '0;
                            state_q <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (bit_pt) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
                        if (bit_q == LAST_B) state_q <= par_en_i ? ST_PAR : ST_STOP;
                        else                 bit_q   <= bit_q + 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_pt) begin
                        cnt_q   <= '0;
                        pbit_q  <= rx_i;
                        state_q <= ST_STOP;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_pt) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // frame result presented while the stop bit is being sampled
    always_comb begin
        done_o = armed_i && (state_q == ST_STOP) && bit_pt;
        data_o = shreg_q;
        fe_o   = ~rx_i;
        pe_o   = par_en_i && ((^shreg_q ^ pbit_q) != par_odd_i);
    end
endmodule

// File: rtl/rx_status.sv
// rx_status: holding register, sticky error flags and interrupt pulses.
// Assumes done_i is a single-cycle strobe. Overrun suppresses the load;
// parity and framing errors do not. Set beats clear on the same cycle.
module rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pe_i,
    input  logic              fe_i,
    input  logic              err_route_i,
    input  logic              buf_rd_i,
    input  logic              stat_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              buf_full_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              ovr_err_o,
    output logic              done_irq_o,
    output logic              err_irq_o
);
    logic ovr;
    logic any_err;

    // overrun: unread byte still held at frame end, no read this cycle
    assign ovr     = buf_full_o && !buf_rd_i;
    assign any_err = pe_i || fe_i || ovr;

    // holding register and full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o  <= '0;
            buf_full_o <= 1'b0;
        end else if (done_i && !ovr) begin
            rx_data_o  <= data_i;
            buf_full_o <= 1'b1;
        end else if (buf_rd_i) begin
            buf_full_o <= 1'b0;
        end
    end

    // sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err_o <= 1'b0;
            frm_err_o <= 1'b0;
            ovr_err_o <= 1'b0;
        end else begin
            par_err_o <= (par_err_o && !stat_clr_i) || (done_i && pe_i);
            frm_err_o <= (frm_err_o && !stat_clr_i) || (done_i && fe_i);
            ovr_err_o <= (ovr_err_o && !stat_clr_i) || (done_i && ovr);
        end
    end

    // interrupt pulse routing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_irq_o <= 1'b0;
            err_irq_o  <= 1'b0;
        end else begin
            done_irq_o <= done_i && (!any_err || !err_route_i);
            err_irq_o  <= done_i && any_err && err_route_i;
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
// uart_rx_core: asynchronous serial receiver top. Joins the line
// synchronizer, the frame sequencer and the status/interrupt unit.
// Assumes tick_i is a one-cycle pulse at OVS times the bit rate.
module uart_rx_core #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              unit_en_i,
    input  logic              rx_en_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              err_route_i,
    input  logic              buf_rd_i,
    input  logic              stat_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              buf_full_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              ovr_err_o,
    output logic              done_irq_o,
    output logic              err_irq_o
);
    logic              rx_s;
    logic              fall;
    logic              armed;
    logic              done;
    logic [DATA_W-1:0] fdata;
    logic              fpe;
    logic              ffe;

    // reception runs only with both enables set
    assign armed = unit_en_i && rx_en_i;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_o   (rx_s),
        .fall_o (fall)
    );

    rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed_i   (armed),
        .tick_i    (tick_i),
        .rx_i      (rx_s),
        .fall_i    (fall),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .done_o    (done),
        .data_o    (fdata),
        .pe_o      (fpe),
        .fe_o      (ffe)
    );

    rx_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done),
        .data_i      (fdata),
        .pe_i        (fpe),
        .fe_i        (ffe),
        .err_route_i (err_route_i),
        .buf_rd_i    (buf_rd_i),
        .stat_clr_i  (stat_clr_i),
        .rx_data_o   (rx_data_o),
        .buf_full_o  (buf_full_o),
        .par_err_o   (par_err_o),
        .frm_err_o   (frm_err_o),
        .ovr_err_o   (ovr_err_o),
        .done_irq_o  (done_irq_o),
        .err_irq_o   (err_irq_o)
    );
endmodule

// File: rtl/rx_checks.sv
// rx_checks: temporal properties of the receiver, observed at its ports.
module rx_checks #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unit_en_i,
    input logic              rx_en_i,
    input logic              err_route_i,
    input logic              stat_clr_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              buf_full_o,
    input logic              par_err_o,
    input logic              frm_err_o,
    input logic              ovr_err_o,
    input logic              done_irq_o,
    input logic              err_irq_o
);
    assert_no_irq_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq_o || err_irq_o) |-> $past(unit_en_i && rx_en_i));

    assert_buf_moves_with_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> (done_irq_o || err_irq_o));

    assert_full_sets_with_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> (done_irq_o || err_irq_o));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    assert_pe_set_at_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err_o) |-> (done_irq_o || err_irq_o));

    assert_fe_set_at_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_err_o) |-> (done_irq_o || err_irq_o));

    assert_overrun_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err_o) |-> $stable(rx_data_o));

    assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_irq_o && err_irq_o));

    assert_err_irq_routed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> $past(err_route_i));

    assert_clear_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_clr_i) && !done_irq_o && !err_irq_o) |-> !(par_err_o || frm_err_o || ovr_err_o));
endmodule

bind uart_rx_core rx_checks #(.DATA_W(DATA_W)) u_rx_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_en_i   (unit_en_i),
    .rx_en_i     (rx_en_i),
    .err_route_i (err_route_i),
    .stat_clr_i  (stat_clr_i),
    .rx_data_o   (rx_data_o),
    .buf_full_o  (buf_full_o),
    .par_err_o   (par_err_o),
    .frm_err_o   (frm_err_o),
    .ovr_err_o   (ovr_err_o),
    .done_irq_o  (done_irq_o),
    .err_irq_o   (err_irq_o)
);

// File: tb/tb_uart_rx_core.sv
// Bench: behavioural reference model compared every clock, plus directed
// per-requirement checks.
module tb_uart_rx_core;
    localparam int OVS  = 8;
    localparam int TDIV = 4;
    localparam int BT   = OVS * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_i = 1'b1, tick_i = 1'b0, unit_en_i = 1'b0, rx_en_i = 1'b0;
    logic par_en_i = 1'b0, par_odd_i = 1'b0, err_route_i = 1'b0;
    logic buf_rd_i = 1'b0, stat_clr_i = 1'b0;
    logic [7:0] rx_data_o;
    logic buf_full_o, par_err_o, frm_err_o, ovr_err_o, done_irq_o, err_irq_o;

    int checks = 0, errors = 0, n_done = 0, n_err = 0;
    string cur_req = "R10";
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_core #(.OVS(OVS), .DATA_W(8), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
        .unit_en_i(unit_en_i), .rx_en_i(rx_en_i), .par_en_i(par_en_i),
        .par_odd_i(par_odd_i), .err_route_i(err_route_i), .buf_rd_i(buf_rd_i),
        .stat_clr_i(stat_clr_i), .rx_data_o(rx_data_o), .buf_full_o(buf_full_o),
        .par_err_o(par_err_o), .frm_err_o(frm_err_o), .ovr_err_o(ovr_err_o),
        .done_irq_o(done_irq_o), .err_irq_o(err_irq_o)
    );

    // tick generator, driven away from the active edge
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv   = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick_i <= (tdiv == 0);
    end

    // reference model state
    logic m_s1, m_s2, m_prev;
    int   m_st, m_cnt, m_bit;
    logic [7:0] m_sh, m_data;
    logic m_pb, m_full, m_pe, m_fe, m_ov, m_done, m_err;

    always @(posedge clk) begin
        logic fall, rxv, fdone, fpe, ffe, ov, anyerr;
        logic [7:0] fdata;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_st = 0; m_cnt = 0; m_bit = 0;
            m_sh = 0; m_pb = 0; m_data = 0; m_full = 0; m_pe = 0; m_fe = 0;
            m_ov = 0; m_done = 0; m_err = 0;
        end else begin
            fall = m_prev & ~m_s2; rxv = m_s2; fdone = 0; fpe = 0; ffe = 0; fdata = m_sh;
            if (!(unit_en_i && rx_en_i)) m_st = 0;
            else if (m_st == 0) begin
                if (fall) begin m_st = 1; m_cnt = 0; end
            end else if (tick_i) begin
                if (m_st == 1) begin
                    if (m_cnt == OVS/2 - 1) begin
                        m_cnt = 0; m_bit = 0; m_st = rxv ? 0 : 2;
                    end else m_cnt++;
                end else if (m_cnt != OVS - 1) m_cnt++;
                else begin
                    m_cnt = 0;
                    if (m_st == 2) begin
                        m_sh = {rxv, m_sh[7:1]};
                        if (m_bit == 7) m_st = par_en_i ? 3 : 4; else m_bit++;
                    end else if (m_st == 3) begin
                        m_pb = rxv; m_st = 4;
                    end else begin
                        fdone = 1; ffe = ~rxv;
                        fpe = par_en_i && ((^m_sh ^ m_pb) != par_odd_i);
                        m_st = 0;
                    end
                end
            end
            ov = fdone && m_full && !buf_rd_i;
            anyerr = fpe || ffe || ov;
            if (buf_rd_i) m_full = 0;
            if (stat_clr_i) begin m_pe = 0; m_fe = 0; m_ov = 0; end
            m_done = 0; m_err = 0;
            if (fdone) begin
                if (!ov) begin m_data = fdata; m_full = 1; end
                if (fpe) m_pe = 1;
                if (ffe) m_fe = 1;
                if (ov)  m_ov = 1;
                m_done = !anyerr || !err_route_i;
                m_err  = anyerr && err_route_i;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_i;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if ({rx_data_o, buf_full_o, par_err_o, frm_err_o, ovr_err_o, done_irq_o, err_irq_o} !==
                {m_data, m_full, m_pe, m_fe, m_ov, m_done, m_err}) begin
                errors++;
                $display("FAIL %s model compare: actual %h/%b%b%b%b%b%b expected %h/%b%b%b%b%b%b",
                    cur_req, rx_data_o, buf_full_o, par_err_o, frm_err_o, ovr_err_o, done_irq_o,
                    err_irq_o, m_data, m_full, m_pe, m_fe, m_ov, m_done, m_err);
            end
            if (done_irq_o) n_done++;
            if (err_irq_o)  n_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rx_i = v;
        repeat (BT) @(negedge clk);
    endtask

    // cut >= 0 drops rx_en after that many data bits
    task automatic send(input logic [7:0] d, input bit par_bad, input logic stop_v, input int cut);
        logic p;
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == cut) begin rx_en_i = 1'b0; rx_i = 1'b1; repeat (3 * BT) @(negedge clk); rx_en_i = 1'b1; return; end
            bit_out(d[i]);
        end
        if (par_en_i) begin
            p = (^d) ^ par_odd_i ^ par_bad;
            bit_out(p);
        end
        bit_out(stop_v);
        rx_i = 1'b1;
        repeat (2 * BT) @(negedge clk);
    endtask

    task automatic pulse_rd();
        buf_rd_i = 1'b1; @(negedge clk); buf_rd_i = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        stat_clr_i = 1'b1; @(negedge clk); stat_clr_i = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0, e0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rx_data_o == 0 && !buf_full_o && !par_err_o && !frm_err_o && !ovr_err_o
            && !done_irq_o && !err_irq_o, "R10", rx_data_o, 0);

        // R1: unit enable off, frame ignored
        cur_req = "R1"; rx_en_i = 1; unit_en_i = 0;
        send(8'h5A, 0, 1, -1);
        chk(n_done == 0 && n_err == 0 && rx_data_o == 0, "R1", n_done + n_err, 0);
        unit_en_i = 1; rx_en_i = 0;
        send(8'h5A, 0, 1, -1);
        chk(n_done == 0 && n_err == 0 && rx_data_o == 0, "R1", rx_data_o, 0);
        rx_en_i = 1;

        // R3 clean frame, LSB first
        cur_req = "R3";
        send(8'hA5, 0, 1, -1);
        chk(rx_data_o == 8'hA5, "R3", rx_data_o, 8'hA5);
        chk(buf_full_o && n_done == 1 && n_err == 0, "R3", n_done, 1);
        cur_req = "R9"; pulse_rd();
        chk(!buf_full_o, "R9", buf_full_o, 0);

        // R4 even parity good then bad, routed to done (R7)
        cur_req = "R4"; par_en_i = 1; par_odd_i = 0; err_route_i = 0;
        send(8'h3C, 0, 1, -1); pulse_rd();
        chk(!par_err_o && rx_data_o == 8'h3C, "R4", par_err_o, 0);
        d0 = n_done; e0 = n_err;
        send(8'h3D, 1, 1, -1); pulse_rd();
        chk(par_err_o && rx_data_o == 8'h3D, "R4", rx_data_o, 8'h3D);
        chk(n_done == d0 + 1 && n_err == e0, "R7", n_done - d0, 1);
        cur_req = "R9"; pulse_clr();
        chk(!par_err_o && !frm_err_o && !ovr_err_o, "R9", par_err_o, 0);
        // odd parity
        cur_req = "R4"; par_odd_i = 1;
        send(8'h81, 0, 1, -1); pulse_rd();
        chk(!par_err_o && rx_data_o == 8'h81, "R4", par_err_o, 0);
        send(8'h81, 1, 1, -1); pulse_rd();
        chk(par_err_o, "R4", par_err_o, 1);
        pulse_clr(); par_en_i = 0;

        // R5 framing error routed to error pulse (R7)
        cur_req = "R5"; err_route_i = 1; d0 = n_done; e0 = n_err;
        send(8'h77, 0, 0, -1);
        chk(frm_err_o && rx_data_o == 8'h77, "R5", rx_data_o, 8'h77);
        chk(n_err == e0 + 1 && n_done == d0, "R7", n_err - e0, 1);
        pulse_clr();

        // R6 overrun: buffer still full from the last frame
        cur_req = "R6"; e0 = n_err;
        send(8'h12, 0, 1, -1);
        chk(ovr_err_o && rx_data_o == 8'h77, "R6", rx_data_o, 8'h77);
        chk(n_err == e0 + 1, "R7", n_err - e0, 1);
        pulse_rd(); pulse_clr(); err_route_i = 0;

        // R2 short glitch rejected
        cur_req = "R2"; d0 = n_done; e0 = n_err;
        rx_i = 0; repeat (3) @(negedge clk); rx_i = 1;
        repeat (2 * BT) @(negedge clk);
        chk(n_done == d0 && n_err == e0 && rx_data_o == 8'h77, "R2", n_done - d0, 0);
        send(8'hC3, 0, 1, -1); pulse_rd();
        chk(rx_data_o == 8'hC3, "R2", rx_data_o, 8'hC3);

        // R8 abort mid-frame
        cur_req = "R8"; d0 = n_done; e0 = n_err;
        send(8'h00, 0, 1, 3);
        chk(n_done == d0 && n_err == e0, "R8", n_done - d0, 0);
        chk(rx_data_o == 8'hC3 && !buf_full_o && !par_err_o && !frm_err_o && !ovr_err_o,
            "R8", rx_data_o, 8'hC3);
        send(8'h9E, 0, 1, -1);
        chk(rx_data_o == 8'h9E && n_done == d0 + 1, "R8", rx_data_o, 8'h9E);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule